// File: doc/BRIEF.md
# Multi-Channel Byte-Copy DMA Engine

This block moves bytes one at a time between a wide memory bus and a small peripheral register page. Each of a set of channels holds its own setup: the copy direction, the way the memory address moves after each byte, a pattern that chooses which peripheral register each byte goes to, the low byte of the first peripheral register, a 24-bit memory address made of a bank byte and a 16-bit offset, and a byte count. A launch write with one bit per channel marks channels as pending. The engine then serves them one at a time, lowest channel number first. Each channel runs to its end before the next one starts.

Every byte is made of two beats: a read on one bus, then a write of the same byte on the other bus. Both buses use a plain request/acknowledge handshake. The engine raises a request with its address, write flag and write data, and holds them until the acknowledge arrives. Read data is taken in the cycle of the acknowledge. The peripheral address always has a fixed upper byte. Its lower byte is the programmed low byte plus an offset, and that offset repeats in a pattern chosen per channel.

Top module: `bytemove_dma`

## Requirements
- R1: After reset, no channel is pending, `busy` is low, and neither `mem_req` nor `per_req` is asserted.
- R2: With control bit 7 at 0, each byte is first read from the memory bus at {bank, offset}. The same byte is then written to the peripheral bus.
- R3: With control bit 7 at 1, each byte is first read from the peripheral bus. The same byte is then written to the memory bus at {bank, offset}.
- R4: With control bit 4 at 1, the memory offset stays the same for every byte. With bit 4 at 0, control bit 3 at 0 adds one per byte and bit 3 at 1 subtracts one per byte. The offset wraps modulo 65536, and the bank byte never changes.
- R5: Control bits 2:0 pick the peripheral offset for byte i of a transfer (i counts from 0 at every transfer start). Code 001 gives i mod 2. Code 011 gives (i/2) mod 2. Code 100 gives i mod 4. Codes 000, 010 and 101 to 111 always give 0.
- R6: Every peripheral address has upper byte PER_PAGE (0x21 by default). Its lower byte is (programmed low byte + offset from R5) mod 256.
- R7: A channel moves exactly its programmed count of bytes. A count of 0 moves 2^CNT_W bytes.
- R8: Pending channels are served lowest number first and never overlap. No bus request is made while nothing is pending.
- R9: A launch write ORs `go_mask` into `pend`. This also works while the engine is busy, and the new bits join the order of R8. A channel's bit clears on the clock edge that completes its last write beat. `busy` is high exactly while any bit is pending, and at most one bit clears per cycle.
- R10: At most one of `mem_req` and `per_req` is high at a time. A request and its address, write flag and write data stay unchanged until acknowledged.
- R11: A setup write stores `cfg_wdata` into channel `cfg_ch`. `cfg_fld` selects the target: 0 control, 1 peripheral low byte, 2 offset low byte, 3 offset high byte, 4 bank, 5 count bits 7:0, 6 count bits CNT_W-1:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_ch | input | CH_W | Channel addressed by the setup write |
| cfg_fld | input | 3 | Field code of the setup write |
| cfg_wdata | input | 8 | Setup write data |
| go_we | input | 1 | Launch write strobe |
| go_mask | input | N_CH | Channels to mark pending, bit i for channel i |
| busy | output | 1 | High while any channel is pending |
| pend | output | N_CH | Pending channel bits |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory bus write flag |
| mem_addr | output | 24 | Memory address {bank, offset} |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory bus acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with acknowledge |
| per_req | output | 1 | Peripheral bus request |
| per_we | output | 1 | Peripheral bus write flag |
| per_addr | output | 16 | Peripheral register address |
| per_wdata | output | 8 | Peripheral write data |
| per_ack | input | 1 | Peripheral bus acknowledge |
| per_rdata | input | 8 | Peripheral read data, valid with acknowledge |

## Verification
A wrong offset, pattern position or remaining count inside the mover shows up at the very next bus beat. It appears as an address or data byte that differs from the expected stream, or as a final beat that comes too early or too late. A bad pending set or a wrong pick order shows within one clock as a mismatch on `pend` or `busy`, or as a beat from the wrong channel. The bench compares both bus streams beat by beat under random acknowledge delays. It also compares `pend` and `busy` on every clock, so no fault can stay hidden past the beat or cycle where it first has an effect.

// File: rtl/bytemove_pkg.sv
package bytemove_pkg;

  localparam int ADR_W  = 16;
  localparam int BANK_W = 8;
  localparam int DW     = 8;
  localparam int MEM_AW = ADR_W + BANK_W;

  // setup field codes
  typedef enum logic [2:0] {
    FLD_CTRL  = 3'd0,
    FLD_PLOW  = 3'd1,
    FLD_ADR_L = 3'd2,
    FLD_ADR_H = 3'd3,
    FLD_BANK  = 3'd4,
    FLD_CNT_L = 3'd5,
    FLD_CNT_H = 3'd6
  } fld_e;

  typedef struct packed {
    logic       to_mem;  // 1: peripheral -> memory
    logic       hold;    // keep memory offset fixed
    logic       down;    // step offset downward
    logic [2:0] pat;     // peripheral offset pattern
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RD,
    ST_WR
  } st_e;

  // peripheral offset for position pos within the repeating pattern
  function automatic logic [1:0] pat_off(input logic [2:0] pat, input logic [1:0] pos);
    case (pat)
      3'b001:  return {1'b0, pos[0]};
      3'b011:  return {1'b0, pos[1]};
      3'b100:  return pos;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bytemove_chregs.sv
module bytemove_chregs
  import bytemove_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  fld_e              fld,
  input  logic [DW-1:0]     wdata,
  output ctrl_t             ctrl,
  output logic [7:0]        plow,
  output logic [ADR_W-1:0]  addr,
  output logic [BANK_W-1:0] bank,
  output logic [CNT_W-1:0]  cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      plow <= '0;
      addr <= '0;
      bank <= '0;
      cnt  <= '0;
    end else if (wr_en) begin
      case (fld)
        FLD_CTRL: begin
          ctrl.to_mem <= wdata[7];
          ctrl.hold   <= wdata[4];
          ctrl.down   <= wdata[3];
          ctrl.pat    <= wdata[2:0];
        end
        FLD_PLOW:  plow          <= wdata;
        FLD_ADR_L: addr[7:0]     <= wdata;
        FLD_ADR_H: addr[15:8]    <= wdata;
        FLD_BANK:  bank          <= wdata;
        FLD_CNT_L: cnt[7:0]      <= wdata;
        FLD_CNT_H: cnt[CNT_W-1:8] <= wdata[CNT_W-9:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bytemove_pick.sv
module bytemove_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/bytemove_xfer.sv
module bytemove_xfer
  import bytemove_pkg::*;
#(
  parameter int          CNT_W    = 16,
  parameter int          CH_W     = 3,
  parameter logic [7:0]  PER_PAGE = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CH_W-1:0]   start_ch,
  input  ctrl_t             ld_ctrl,
  input  logic [7:0]        ld_plow,
  input  logic [ADR_W-1:0]  ld_addr,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [CNT_W-1:0]  ld_cnt,
  output logic              idle,
  output logic              done,
  output logic [CH_W-1:0]   done_ch,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              per_req,
  output logic              per_we,
  output logic [15:0]       per_addr,
  output logic [DW-1:0]     per_wdata,
  input  logic              per_ack,
  input  logic [DW-1:0]     per_rdata
);

  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  st_e               st_q;
  logic [CH_W-1:0]   ch_q;
  ctrl_t             ctrl_q;
  logic [7:0]        plow_q;
  logic [ADR_W-1:0]  addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W:0]    left_q;
  logic [1:0]        pos_q;

  logic              rd_ack, wr_ack, last;
  logic [DW-1:0]     rd_data;
  logic [15:0]       per_cur;
  logic [MEM_AW-1:0] mem_cur;
  logic [ADR_W-1:0]  addr_nxt;

  assign rd_ack  = ctrl_q.to_mem ? per_ack   : mem_ack;
  assign wr_ack  = ctrl_q.to_mem ? mem_ack   : per_ack;
  assign rd_data = ctrl_q.to_mem ? per_rdata : mem_rdata;
  assign per_cur = {PER_PAGE, plow_q + {6'd0, pat_off(ctrl_q.pat, pos_q)}};
  assign mem_cur = {bank_q, addr_q};
  assign last    = (left_q == {{CNT_W{1'b0}}, 1'b1});

  always_comb begin
    if (ctrl_q.hold)      addr_nxt = addr_q;
    else if (ctrl_q.down) addr_nxt = addr_q - 1'b1;
    else                  addr_nxt = addr_q + 1'b1;
  end

  assign idle    = (st_q == ST_IDLE);
  assign done    = (st_q == ST_WR) && wr_ack && last;
  assign done_ch = ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ch_q      <= '0;
      ctrl_q    <= '0;
      plow_q    <= '0;
      addr_q    <= '0;
      bank_q    <= '0;
      left_q    <= '0;
      pos_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      per_req   <= 1'b0;
      per_we    <= 1'b0;
      per_addr  <= '0;
      per_wdata <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            ch_q   <= start_ch;
            ctrl_q <= ld_ctrl;
            plow_q <= ld_plow;
            addr_q <= ld_addr;
            bank_q <= ld_bank;
            left_q <= (ld_cnt == '0) ? FULL : {1'b0, ld_cnt};
            pos_q  <= '0;
            st_q   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (ctrl_q.to_mem) begin
            per_req  <= 1'b1;
            per_we   <= 1'b0;
            per_addr <= per_cur;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= mem_cur;
          end
          st_q <= ST_RD;
        end
        ST_RD: begin
          if (rd_ack) begin
            if (ctrl_q.to_mem) begin
              per_req   <= 1'b0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= mem_cur;
              mem_wdata <= rd_data;
            end else begin
              mem_req   <= 1'b0;
              per_req   <= 1'b1;
              per_we    <= 1'b1;
              per_addr  <= per_cur;
              per_wdata <= rd_data;
            end
            st_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_ack) begin
            mem_req <= 1'b0;
            per_req <= 1'b0;
            addr_q  <= addr_nxt;
            pos_q   <= pos_q + 1'b1;
            left_q  <= left_q - 1'b1;
            st_q    <= last ? ST_IDLE : ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bytemove_dma.sv
module bytemove_dma
  import bytemove_pkg::*;
#(
  parameter int         N_CH     = 8,
  parameter int         CNT_W    = 16,
  parameter logic [7:0] PER_PAGE = 8'h21,
  localparam int        CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [2:0]        cfg_fld,
  input  logic [7:0]        cfg_wdata,
  input  logic              go_we,
  input  logic [N_CH-1:0]   go_mask,
  output logic              busy,
  output logic [N_CH-1:0]   pend,
  output logic              mem_req,
  output logic              mem_we,
  output logic [23:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              per_req,
  output logic              per_we,
  output logic [15:0]       per_addr,
  output logic [7:0]        per_wdata,
  input  logic              per_ack,
  input  logic [7:0]        per_rdata
);

  ctrl_t             ctrl_a [N_CH];
  logic [7:0]        plow_a [N_CH];
  logic [ADR_W-1:0]  addr_a [N_CH];
  logic [BANK_W-1:0] bank_a [N_CH];
  logic [CNT_W-1:0]  cnt_a  [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    bytemove_chregs #(.CNT_W(CNT_W)) u_regs (
      .clk   (clk),
      .rst   (rst),
      .wr_en (cfg_we && (cfg_ch == CH_W'(i))),
      .fld   (fld_e'(cfg_fld)),
      .wdata (cfg_wdata),
      .ctrl  (ctrl_a[i]),
      .plow  (plow_a[i]),
      .addr  (addr_a[i]),
      .bank  (bank_a[i]),
      .cnt   (cnt_a[i])
    );
  end

  logic [N_CH-1:0] pend_q, clr;
  logic            any, idle, done;
  logic [CH_W-1:0] sel, done_ch;

  bytemove_pick #(.N(N_CH), .IW(CH_W)) u_pick (
    .req (pend_q),
    .any (any),
    .idx (sel)
  );

  bytemove_xfer #(.CNT_W(CNT_W), .CH_W(CH_W), .PER_PAGE(PER_PAGE)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .start     (idle && any),
    .start_ch  (sel),
    .ld_ctrl   (ctrl_a[sel]),
    .ld_plow   (plow_a[sel]),
    .ld_addr   (addr_a[sel]),
    .ld_bank   (bank_a[sel]),
    .ld_cnt    (cnt_a[sel]),
    .idle      (idle),
    .done      (done),
    .done_ch   (done_ch),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .per_req   (per_req),
    .per_we    (per_we),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .per_ack   (per_ack),
    .per_rdata (per_rdata)
  );

  always_comb begin
    clr = '0;
    if (done) clr[done_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | (go_we ? go_mask : '0);
  end

  assign pend = pend_q;
  assign busy = |pend_q;

endmodule

// File: rtl/bytemove_dma_chk.sv
module bytemove_dma_chk #(
  parameter int         N_CH     = 8,
  parameter logic [7:0] PER_PAGE = 8'h21
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic [N_CH-1:0] pend,
  input logic            mem_req,
  input logic            mem_we,
  input logic [23:0]     mem_addr,
  input logic [7:0]      mem_wdata,
  input logic            mem_ack,
  input logic            per_req,
  input logic            per_we,
  input logic [15:0]     per_addr,
  input logic [7:0]      per_wdata,
  input logic            per_ack
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (pend == '0 && !mem_req && !per_req));

  p_one_bus_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && per_req));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_per_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (per_req && !per_ack) |=> (per_req && $stable(per_addr) && $stable(per_we) && $stable(per_wdata)));

  p_per_page_r6: assert property (@(posedge clk) disable iff (rst)
    per_req |-> (per_addr[15:8] == PER_PAGE));

  p_single_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $countones($past(pend) & ~pend) <= 1);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past((mem_req && mem_ack) || (per_req && per_ack)));

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !per_req));

endmodule

bind bytemove_dma bytemove_dma_chk #(.N_CH(N_CH), .PER_PAGE(PER_PAGE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .pend      (pend),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .per_req   (per_req),
  .per_we    (per_we),
  .per_addr  (per_addr),
  .per_wdata (per_wdata),
  .per_ack   (per_ack)
);

// File: tb/bytemove_dma_bench.sv
`timescale 1ns/1ps
module bytemove_dma_bench;

  localparam int NC = 8;
  localparam int CW = 10;

  typedef struct packed {
    logic        side;   // 0 memory, 1 peripheral
    logic        we;
    logic [23:0] addr;
    logic [7:0]  data;
    logic        last;
  } beat_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_ch = '0;
  logic [2:0]    cfg_fld = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          go_we = 1'b0;
  logic [NC-1:0] go_mask = '0;
  logic          busy;
  logic [NC-1:0] pend;
  logic          mem_req, mem_we, per_req, per_we;
  logic [23:0]   mem_addr;
  logic [15:0]   per_addr;
  logic [7:0]    mem_wdata, per_wdata, mem_rdata, per_rdata;
  logic          mem_ack = 1'b0;
  logic          per_ack = 1'b0;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] perf(input logic [15:0] a);
    return (a[7:0] + {a[6:0], 1'b0}) ^ 8'hC3;
  endfunction
  function automatic int poff(input logic [2:0] pat, input int i);
    if (pat == 3'b001) return i % 2;
    if (pat == 3'b011) return (i / 2) % 2;
    if (pat == 3'b100) return i % 4;
    return 0;
  endfunction

  assign mem_rdata = memf(mem_addr);
  assign per_rdata = perf(per_addr);

  bytemove_dma #(.N_CH(NC), .CNT_W(CW)) u_bytemove_dma (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
    .go_we(go_we), .go_mask(go_mask), .busy(busy), .pend(pend),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_ack(per_ack), .per_rdata(per_rdata)
  );

  int total = 0;
  int bad = 0;
  bit armed = 1'b0;
  int cur = 0;
  beat_t q[$];
  logic [7:0]    m_ctrl [NC];
  logic [7:0]    m_plow [NC];
  logic [7:0]    m_bank [NC];
  logic [15:0]   m_addr [NC];
  logic [CW-1:0] m_cnt  [NC];
  logic [NC-1:0] m_pend = '0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected beat stream of one channel, built from the requirements
  task automatic build(input int ch);
    int n;
    logic [15:0] a;
    logic [7:0] pl;
    logic [23:0] ma;
    logic [15:0] pa;
    n = (m_cnt[ch] == '0) ? (1 << CW) : int'(m_cnt[ch]);   // R7
    a = m_addr[ch];
    for (int i = 0; i < n; i++) begin
      pl = m_plow[ch] + 8'(poff(m_ctrl[ch][2:0], i));       // R5
      pa = {8'h21, pl};                                       // R6
      ma = {m_bank[ch], a};
      if (!m_ctrl[ch][7]) begin                              // R2
        q.push_back('{1'b0, 1'b0, ma, 8'h00, 1'b0});
        q.push_back('{1'b1, 1'b1, {8'h00, pa}, memf(ma), i == n - 1});
      end else begin                                          // R3
        q.push_back('{1'b1, 1'b0, {8'h00, pa}, 8'h00, 1'b0});
        q.push_back('{1'b0, 1'b1, ma, perf(pa), i == n - 1});
      end
      if (!m_ctrl[ch][4]) a = m_ctrl[ch][3] ? a - 16'd1 : a + 16'd1;  // R4
    end
  endtask

  task automatic take(input logic side, input logic we, input logic [23:0] addr, input logic [7:0] data);
    beat_t h;
    string dtag;
    if (q.size() == 0) begin
      if (m_pend == '0) begin
        chk(1'b0, "R8 beat with nothing pending", {7'd0, side, addr}, 32'h0);
        return;
      end
      for (int i = NC - 1; i >= 0; i--) if (m_pend[i]) cur = i;   // R8 lowest first
      build(cur);
    end
    h = q.pop_front();
    dtag = m_ctrl[cur][7] ? "R3" : "R2";
    chk(side == h.side && we == h.we, dtag, {30'd0, side, we}, {30'd0, h.side, h.we});
    if (side) begin
      chk(addr == h.addr, "R5", {8'd0, addr}, {8'd0, h.addr});
      chk(addr[15:8] == 8'h21, "R6", {24'd0, addr[15:8]}, 32'h21);
    end else begin
      chk(addr == h.addr, "R4", {8'd0, addr}, {8'd0, h.addr});
    end
    if (we) chk(data == h.data, dtag, {24'd0, data}, {24'd0, h.data});
    if (h.last) m_pend[cur] = 1'b0;
  endtask

  // bus slaves with random acknowledge delay
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ack = 1'b0;
    per_ack = 1'b0;
    if (!rst) begin
      if (mem_req && lfsr[0]) begin
        mem_ack = 1'b1;
        take(1'b0, mem_we, mem_addr, mem_wdata);
      end
      if (per_req && lfsr[3]) begin
        per_ack = 1'b1;
        take(1'b1, per_we, {8'h00, per_addr}, per_wdata);
      end
    end
  end

  // every-clock comparison of pending set, busy and idle quiet
  always @(posedge clk) begin
    #1;
    if (armed && !rst) begin
      chk(pend == m_pend, "R9", {24'd0, pend}, {24'd0, m_pend});
      chk(busy == (m_pend != '0), "R9", {31'd0, busy}, {31'd0, m_pend != '0});
      if (m_pend == '0) chk(!mem_req && !per_req, "R8", {30'd0, mem_req, per_req}, 32'd0);
      chk(!(mem_req && per_req), "R10", {30'd0, mem_req, per_req}, 32'd0);
    end
  end

  task automatic setup(input int ch, input logic [7:0] ctrl, input logic [7:0] plow,
                       input logic [15:0] addr, input logic [7:0] bank, input logic [15:0] cnt);
    logic [7:0] vals [7];
    vals[0] = ctrl; vals[1] = plow; vals[2] = addr[7:0]; vals[3] = addr[15:8];
    vals[4] = bank; vals[5] = cnt[7:0]; vals[6] = cnt[15:8];
    for (int f = 0; f < 7; f++) begin      // R11 field codes 0..6
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_fld = 3'(f); cfg_wdata = vals[f];
    end
    @(negedge clk);
    cfg_we = 1'b0;
    m_ctrl[ch] = ctrl; m_plow[ch] = plow; m_addr[ch] = addr;
    m_bank[ch] = bank; m_cnt[ch] = cnt[CW-1:0];
  endtask

  task automatic launch(input logic [NC-1:0] mask);
    @(negedge clk);
    go_we = 1'b1; go_mask = mask;
    m_pend = m_pend | mask;
    @(negedge clk);
    go_we = 1'b0; go_mask = '0;
  endtask

  task automatic wait_idle();
    while (m_pend != '0 || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7", q.size(), 32'd0);
    chk(!busy && pend == '0, "R9", {23'd0, busy, pend}, 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!busy, "R1", {31'd0, busy}, 32'd0);
    chk(pend == '0, "R1", {24'd0, pend}, 32'd0);
    chk(!mem_req && !per_req, "R1", {30'd0, mem_req, per_req}, 32'd0);
    armed = 1'b1;

    // R2 R5: memory to peripheral, pattern 001, incrementing
    setup(0, 8'h01, 8'h18, 16'h1234, 8'h7E, 16'd6);
    launch(8'h01);
    wait_idle();

    // R3 R4: peripheral to memory, pattern 011, decrementing through zero
    setup(1, 8'h8B, 8'h40, 16'h0002, 8'h12, 16'd9);
    launch(8'h02);
    wait_idle();

    // R4 R6: fixed offset, pattern 100, low byte wraps
    setup(2, 8'h14, 8'hFE, 16'hFFFE, 8'h00, 16'd7);
    launch(8'h04);
    wait_idle();

    // R8: several channels in one launch, served lowest first
    setup(5, 8'h00, 8'h80, 16'hFFFF, 8'hC0, 16'd4);
    setup(7, 8'h85, 8'h22, 16'h0100, 8'h01, 16'd5);
    launch(8'hA5);
    wait_idle();

    // R9: launch while busy joins the order (expect 3, 0, 6)
    setup(3, 8'h02, 8'h30, 16'h5000, 8'h44, 16'd8);
    setup(6, 8'h9C, 8'h60, 16'h7777, 8'h55, 16'd6);
    launch(8'h48);
    repeat (12) @(negedge clk);
    launch(8'h01);
    wait_idle();

    // R7: count 0 moves 2^CW bytes, offset wraps within 16 bits
    setup(4, 8'h04, 8'h10, 16'hFF00, 8'h33, 16'd0);
    launch(8'h10);
    wait_idle();

    // R5: pattern restarts at every transfer start
    setup(1, 8'h04, 8'h08, 16'h2000, 8'h09, 16'd3);
    launch(8'h02);
    wait_idle();
    launch(8'h02);
    wait_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule